// File: doc/BRIEF.md
# Host Register Bank Front End

This block is a 32-bit memory-mapped register bank placed in front of a standard SD host slot register window. It decodes a 4 KiB address space. The low addresses reach a small array of vendor host registers held in the block itself. Addresses from `SLOT_BASE` (0x200 by default) up to the top of the window are forwarded to a separate slot-register port. The block then returns that port's response to the host.

Three vendor registers have their own write rules:
- The general-information word holds a self-clearing soft reset. That reset restores the whole vendor bank and pulses a reset to the slot logic.
- The PHY access port stores the written word, but its acknowledge bit follows whether a read or write request bit was written.
- The eMMC control word never keeps its tuning-request bit.

The slot interrupt reaches the block's interrupt output with no register in the path. The host keeps at most one request outstanding. Every request receives exactly one response, one cycle after it is presented.

Top module: `sdh_vendor_regbank`

## Requirements
- R1: After reset, the word at byte offset 0x00 reads 0x00010000 and every other vendor word reads 0x00000000.
- R2: A full-word, word-aligned write below the vendor bank span (0x40 bytes by default) stores all 32 bits, except at offsets 0x00, 0x10 and 0x18. A read returns the stored word on `rsp_rdata`, with `rsp_valid` high, in the cycle after the request.
- R3: A full-word write to offset 0x00 with bit 0 set restores every vendor word to its R1 value on the sampling clock edge. A write to 0x00 with bit 0 clear changes nothing. Offset 0x00 never takes the written value, so its bit 0 always reads 0.
- R4: The soft reset of R3 raises `slot_rst` for exactly one cycle, in the cycle after the write request.
- R5: A write to offset 0x10 stores the written word, with bit 26 replaced by (bit 24 OR bit 25) of the written value.
- R6: A write to offset 0x18 stores the written word with bit 15 forced to 0.
- R7: A full-word, word-aligned request at an address from 0x200 up to 0xFFC is forwarded in the same cycle on the `slot_req_*` outputs. `slot_req_addr` is the host address minus 0x200. The slot response appears on `rsp_valid`/`rsp_rdata`.
- R8: A request is answered one cycle later with `rsp_valid` high and data 0, and is neither stored nor forwarded, if any of these holds:
  - `req_be` is not 4'hF;
  - the address is not word-aligned;
  - the address lies in the gap between the vendor bank span and 0x200.
- R9: `irq` equals `slot_irq` in every cycle, including the `slot_rst` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_be | input | DATA_W/8 | Byte enables; only all ones is accepted |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | DATA_W | Read data (0 for writes and refused requests) |
| slot_req_valid | output | 1 | Forwarded request strobe |
| slot_req_write | output | 1 | Forwarded write flag |
| slot_req_addr | output | ADDR_W | Address relative to the slot window base |
| slot_req_wdata | output | DATA_W | Forwarded write data |
| slot_rsp_valid | input | 1 | Slot response strobe |
| slot_rsp_rdata | input | DATA_W | Slot response data |
| slot_rst | output | 1 | One-cycle reset pulse to the slot logic |
| slot_irq | input | 1 | Slot interrupt |
| irq | output | 1 | Interrupt to the system |

## Verification
The soft-reset pulse to the slot logic and the interrupt pass-through can fall in the same cycle. The bench holds `slot_irq` high and then issues the soft-reset write. In the cycle where `slot_rst` is high, it checks that `irq` is still high and that the bank is back at its power-on values. The test is then repeated with `slot_irq` low. A second overlap is a vendor bank response in the cycle right after a forwarded slot access. Back-to-back slot and vendor requests check that each response carries only its own data.

// File: rtl/sdhv_pkg.sv
package sdhv_pkg;
   typedef enum logic [1:0] {
      TGT_VEND = 2'd0,
      TGT_SLOT = 2'd1,
      TGT_NONE = 2'd2
   } sdhv_tgt_e;

   // word indices of the vendor registers with write side effects
   localparam int unsigned IDX_GENINFO = 0;
   localparam int unsigned IDX_PHYPORT = 4;
   localparam int unsigned IDX_EMMCCTL = 6;

   // bit positions
   localparam int unsigned BIT_SOFTRST  = 0;
   localparam int unsigned BIT_PHY_WREQ = 24;
   localparam int unsigned BIT_PHY_RREQ = 25;
   localparam int unsigned BIT_PHY_ACK  = 26;
   localparam int unsigned BIT_TUNE     = 15;
endpackage

// File: rtl/sdhv_decode.sv
module sdhv_decode
   import sdhv_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_VREGS = 16,
   parameter int unsigned SLOT_BASE = 32'h200
) (
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [DATA_W/8-1:0]                be,
   output sdhv_tgt_e                          tgt,
   output logic [$clog2(NUM_VREGS)-1:0]       vidx
);
   localparam int unsigned BYTES  = DATA_W / 8;
   localparam int unsigned ALGN_W = $clog2(BYTES);
   localparam int unsigned IDX_W  = $clog2(NUM_VREGS);
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_VREGS * BYTES);
   localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_BASE);

   logic full_word;
   logic aligned;

   assign full_word = &be;
   assign aligned   = (addr[ALGN_W-1:0] == '0);
   assign vidx      = addr[ALGN_W +: IDX_W];

   always_comb begin
      tgt = TGT_NONE;
      if (full_word && aligned) begin
         if (addr < SPAN_A)        tgt = TGT_VEND;
         else if (addr >= SLOT_A)  tgt = TGT_SLOT;
      end
   end
endmodule

// File: rtl/sdhv_wr_shape.sv
module sdhv_wr_shape
   import sdhv_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic              st_en,
   output logic [DATA_W-1:0] st_data,
   output logic              srst
);
   always_comb begin
      st_en   = 1'b1;
      st_data = wdata;
      srst    = 1'b0;
      if (idx == IDX_W'(IDX_GENINFO)) begin
         // only the self-clearing reset bit acts; the word never stores
         st_en = 1'b0;
         srst  = wdata[BIT_SOFTRST];
      end else if (idx == IDX_W'(IDX_PHYPORT)) begin
         st_data[BIT_PHY_ACK] = wdata[BIT_PHY_WREQ] | wdata[BIT_PHY_RREQ];
      end else if (idx == IDX_W'(IDX_EMMCCTL)) begin
         st_data[BIT_TUNE] = 1'b0;
      end
   end
endmodule

// File: rtl/sdhv_bank.sv
module sdhv_bank #(
   parameter int unsigned      DATA_W    = 32,
   parameter int unsigned      NUM_VREGS = 16,
   parameter logic [DATA_W-1:0] GEN_POR  = 32'h0001_0000
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  clr,
   input  logic                                  wr_en,
   input  logic [$clog2(NUM_VREGS)-1:0]          wr_idx,
   input  logic [DATA_W-1:0]                     wr_data,
   output logic [NUM_VREGS-1:0][DATA_W-1:0]      bank_q
);
   localparam int unsigned IDX_W = $clog2(NUM_VREGS);

   for (genvar g = 0; g < NUM_VREGS; g++) begin : g_word
      localparam logic [DATA_W-1:0] POR_V = (g == 0) ? GEN_POR : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank_q[g] <= POR_V;
         else if (clr)
            bank_q[g] <= POR_V;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            bank_q[g] <= wr_data;
      end
   end
endmodule

// File: rtl/sdh_vendor_regbank.sv
module sdh_vendor_regbank
   import sdhv_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 12,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       NUM_VREGS = 16,
   parameter int unsigned       SLOT_BASE = 32'h200,
   parameter logic [DATA_W-1:0] GEN_POR   = 32'h0001_0000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W/8-1:0]   req_be,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic                  slot_req_valid,
   output logic                  slot_req_write,
   output logic [ADDR_W-1:0]     slot_req_addr,
   output logic [DATA_W-1:0]     slot_req_wdata,
   input  logic                  slot_rsp_valid,
   input  logic [DATA_W-1:0]     slot_rsp_rdata,
   output logic                  slot_rst,
   input  logic                  slot_irq,
   output logic                  irq
);
   localparam int unsigned IDX_W  = $clog2(NUM_VREGS);
   localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_BASE);

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_width
      $error("sdh_vendor_regbank: DATA_W must be 32");
   end
   if ((1 << IDX_W) != NUM_VREGS || NUM_VREGS <= IDX_EMMCCTL) begin : g_bad_depth
      $error("sdh_vendor_regbank: NUM_VREGS must be a power of two above the eMMC index");
   end
   if (NUM_VREGS * (DATA_W / 8) > SLOT_BASE || SLOT_BASE >= (1 << ADDR_W)) begin : g_bad_map
      $error("sdh_vendor_regbank: vendor span must end below SLOT_BASE inside the window");
   end

   sdhv_tgt_e                        tgt;
   logic [IDX_W-1:0]                 vidx;
   logic                             sh_en;
   logic [DATA_W-1:0]                sh_data;
   logic                             sh_srst;
   logic                             vend_wr;
   logic                             srst_fire;
   logic [NUM_VREGS-1:0][DATA_W-1:0] bank_q;
   logic                             vend_rsp_q;
   logic [DATA_W-1:0]                rdata_q;
   logic                             slot_rst_q;

   sdhv_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VREGS(NUM_VREGS), .SLOT_BASE(SLOT_BASE)
   ) u_decode (
      .addr(req_addr), .be(req_be), .tgt(tgt), .vidx(vidx)
   );

   sdhv_wr_shape #(
      .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_shape (
      .idx(vidx), .wdata(req_wdata), .st_en(sh_en), .st_data(sh_data), .srst(sh_srst)
   );

   assign vend_wr   = req_valid && req_write && (tgt == TGT_VEND);
   assign srst_fire = vend_wr && sh_srst;

   sdhv_bank #(
      .DATA_W(DATA_W), .NUM_VREGS(NUM_VREGS), .GEN_POR(GEN_POR)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(srst_fire), .wr_en(vend_wr && sh_en),
      .wr_idx(vidx), .wr_data(sh_data), .bank_q(bank_q)
   );

   // local response path: vendor reads and refused requests
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vend_rsp_q <= 1'b0;
         rdata_q    <= '0;
         slot_rst_q <= 1'b0;
      end else begin
         vend_rsp_q <= req_valid && (tgt != TGT_SLOT);
         rdata_q    <= (req_valid && !req_write && (tgt == TGT_VEND)) ? bank_q[vidx] : '0;
         slot_rst_q <= srst_fire;
      end
   end

   assign slot_req_valid = req_valid && (tgt == TGT_SLOT);
   assign slot_req_write = req_write;
   assign slot_req_addr  = req_addr - SLOT_A;
   assign slot_req_wdata = req_wdata;

   assign rsp_valid = vend_rsp_q | slot_rsp_valid;
   assign rsp_rdata = vend_rsp_q     ? rdata_q :
                      slot_rsp_valid ? slot_rsp_rdata : '0;
   assign slot_rst  = slot_rst_q;
   assign irq       = slot_irq;
endmodule

// File: rtl/sdhv_chk.sv
module sdhv_chk #(
   parameter int unsigned       ADDR_W    = 12,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       NUM_VREGS = 16,
   parameter int unsigned       SLOT_BASE = 32'h200,
   parameter logic [DATA_W-1:0] GEN_POR   = 32'h0001_0000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [DATA_W/8-1:0] req_be,
   input logic [2:0]          wd_bits,   // {rd req, wr req, soft reset}
   input logic                rsp_valid,
   input logic                slot_req_valid,
   input logic                slot_rst,
   input logic [DATA_W-1:0]   gen_q,
   input logic                phy_ack_q,
   input logic                tune_q
);
   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_VREGS * (DATA_W / 8));
   localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_BASE);
   localparam logic [ADDR_W-1:0] PHY_A  = ADDR_W'(16);

   logic ok_acc, wr_gen_rst, wr_phy, in_gap;
   assign ok_acc     = req_valid && (&req_be) && (req_addr[1:0] == 2'b00);
   assign wr_gen_rst = ok_acc && req_write && (req_addr == '0) && wd_bits[0];
   assign wr_phy     = ok_acc && req_write && (req_addr == PHY_A);
   assign in_gap     = req_valid && (req_addr >= SPAN_A) && (req_addr < SLOT_A);

   AST_VEND_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_addr < SLOT_A)) |=> rsp_valid);                      // R2
   AST_SRST_POR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gen_rst |=> (gen_q == GEN_POR) && !phy_ack_q);                      // R3
   AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gen_rst |=> slot_rst);                                              // R4
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_rst |=> !slot_rst);                                               // R4
   AST_PHY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_phy |=> (phy_ack_q == ($past(wd_bits[1]) || $past(wd_bits[2]))));   // R5
   AST_TUNE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !tune_q);                                                              // R6
   AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      in_gap |-> !slot_req_valid);                                           // R8
endmodule

bind sdh_vendor_regbank sdhv_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VREGS(NUM_VREGS),
   .SLOT_BASE(SLOT_BASE), .GEN_POR(GEN_POR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_be(req_be),
   .wd_bits({req_wdata[25], req_wdata[24], req_wdata[0]}),
   .rsp_valid(rsp_valid), .slot_req_valid(slot_req_valid), .slot_rst(slot_rst),
   .gen_q(bank_q[0]), .phy_ack_q(bank_q[4][26]), .tune_q(bank_q[6][15])
);

// File: tb/test_sdh_vendor_regbank.sv
module test_sdh_vendor_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        slot_req_valid, slot_req_write;
   logic [11:0] slot_req_addr;
   logic [31:0] slot_req_wdata;
   logic        slot_rsp_valid;
   logic [31:0] slot_rsp_rdata;
   logic        slot_rst;
   logic        slot_irq = 1'b0;
   logic        irq;

   int checks = 0, errors = 0;
   bit done = 0;
   int          seen_cnt;
   logic [11:0] seen_addr;
   logic        seen_write;
   logic [31:0] seen_wdata;

   always #5 clk = ~clk;

   sdh_vendor_regbank i_sdh_vendor_regbank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .slot_req_valid(slot_req_valid), .slot_req_write(slot_req_write),
      .slot_req_addr(slot_req_addr), .slot_req_wdata(slot_req_wdata),
      .slot_rsp_valid(slot_rsp_valid), .slot_rsp_rdata(slot_rsp_rdata),
      .slot_rst(slot_rst), .slot_irq(slot_irq), .irq(irq)
   );

   // slot register model: answers one cycle after each forwarded request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_rsp_valid <= 1'b0;
         slot_rsp_rdata <= '0;
         seen_cnt       <= 0;
         seen_addr      <= '0;
         seen_write     <= 1'b0;
         seen_wdata     <= '0;
      end else begin
         slot_rsp_valid <= slot_req_valid;
         slot_rsp_rdata <= (slot_req_valid && !slot_req_write) ? {20'hC0DE0, slot_req_addr} : '0;
         if (slot_req_valid) begin
            seen_cnt   <= seen_cnt + 1;
            seen_addr  <= slot_req_addr;
            seen_write <= slot_req_write;
            seen_wdata <= slot_req_wdata;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // one request; returns response sampled in the following cycle
   task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [3:0] be, output logic [31:0] rd, output bit rv,
                      output bit rstp);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_be = '0;
      rd = rsp_rdata; rv = rsp_valid; rstp = slot_rst;
   endtask

   task automatic wr32(input logic [11:0] a, input logic [31:0] d);
      logic [31:0] rd; bit rv, rp;
      acc(1'b1, a, d, 4'hF, rd, rv, rp);
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] rd; bit rv, rp;
      acc(1'b0, a, 32'h0, 4'hF, rd, rv, rp);
      chk({tag, " rsp_valid"}, 32'(rv), 32'd1);
      chk(tag, rd, exp);
   endtask

   task automatic t_reset_values;
      rd_chk("R1 geninfo", 12'h000, 32'h0001_0000);
      for (int i = 1; i < 16; i++) rd_chk("R1 zero word", 12'(i * 4), 32'h0);
   endtask

   task automatic t_plain_rw;
      wr32(12'h004, 32'hDEAD_BEEF);
      wr32(12'h03C, 32'h0123_4567);
      wr32(12'h008, 32'hFFFF_FFFF);
      rd_chk("R2 word1", 12'h004, 32'hDEAD_BEEF);
      rd_chk("R2 word15", 12'h03C, 32'h0123_4567);
      rd_chk("R2 word2", 12'h008, 32'hFFFF_FFFF);
      wr32(12'h008, 32'h0000_0000);
      rd_chk("R2 word2 cleared", 12'h008, 32'h0);
   endtask

   task automatic t_phy;
      wr32(12'h010, 32'h0100_00AA);  // write request
      rd_chk("R5 wr req ack", 12'h010, 32'h0500_00AA);
      wr32(12'h010, 32'h0200_0001);  // read request
      rd_chk("R5 rd req ack", 12'h010, 32'h0600_0001);
      wr32(12'h010, 32'h0400_1234);  // ack alone written
      rd_chk("R5 no req ack low", 12'h010, 32'h0000_1234);
      wr32(12'h010, 32'h0300_0000);  // both requests
      rd_chk("R5 both req", 12'h010, 32'h0700_0000);
   endtask

   task automatic t_emmc;
      wr32(12'h018, 32'hFFFF_FFFF);
      rd_chk("R6 tune cleared", 12'h018, 32'hFFFF_7FFF);
      wr32(12'h018, 32'h0000_8001);
      rd_chk("R6 tune alone", 12'h018, 32'h0000_0001);
   endtask

   task automatic t_softreset(input bit irq_lvl);
      logic [31:0] rd; bit rv, rp;
      wr32(12'h004, 32'h1111_2222);
      wr32(12'h010, 32'h0100_0000);
      acc(1'b1, 12'h000, 32'hFFFF_FFFE, 4'hF, rd, rv, rp);
      chk("R4 no pulse bit0 clear", 32'(rp), 32'd0);
      rd_chk("R3 geninfo unchanged", 12'h000, 32'h0001_0000);
      rd_chk("R3 word1 kept", 12'h004, 32'h1111_2222);
      slot_irq = irq_lvl;
      acc(1'b1, 12'h000, 32'h0000_0001, 4'hF, rd, rv, rp);
      chk("R4 pulse high", 32'(rp), 32'd1);
      chk("R9 irq during slot_rst", 32'(irq), 32'(irq_lvl));
      @(negedge clk);
      chk("R4 pulse one cycle", 32'(slot_rst), 32'd0);
      slot_irq = 1'b0;
      rd_chk("R3 geninfo por", 12'h000, 32'h0001_0000);
      rd_chk("R3 word1 cleared", 12'h004, 32'h0);
      rd_chk("R3 phy cleared", 12'h010, 32'h0);
   endtask

   task automatic t_slot;
      logic [31:0] rd; bit rv, rp;
      int c0;
      c0 = seen_cnt;
      rd_chk("R7 slot read base", 12'h200, 32'hC0DE_0000);
      chk("R7 slot addr base", 32'(seen_addr), 32'h0);
      rd_chk("R7 slot read top", 12'hFFC, 32'hC0DE_0DFC);
      acc(1'b1, 12'h3FC, 32'hCAFE_F00D, 4'hF, rd, rv, rp);
      chk("R7 slot wr rsp", 32'(rv), 32'd1);
      chk("R7 slot wr addr", 32'(seen_addr), 32'h1FC);
      chk("R7 slot wr data", seen_wdata, 32'hCAFE_F00D);
      chk("R7 slot wr flag", 32'(seen_write), 32'd1);
      chk("R7 slot count", 32'(seen_cnt - c0), 32'd3);
      // vendor read straight after slot access
      rd_chk("R2 vendor after slot", 12'h03C, 32'h0);
   endtask

   task automatic t_refused;
      logic [31:0] rd; bit rv, rp;
      int c0;
      wr32(12'h00C, 32'h5555_AAAA);
      c0 = seen_cnt;
      acc(1'b1, 12'h00C, 32'h1234_5678, 4'h3, rd, rv, rp);
      chk("R8 partial wr rsp", 32'(rv), 32'd1);
      rd_chk("R8 partial wr ignored", 12'h00C, 32'h5555_AAAA);
      acc(1'b0, 12'h00C, 32'h0, 4'hE, rd, rv, rp);
      chk("R8 partial rd zero", rd, 32'h0);
      acc(1'b1, 12'h00E, 32'h0, 4'hF, rd, rv, rp);
      rd_chk("R8 misaligned ignored", 12'h00C, 32'h5555_AAAA);
      acc(1'b1, 12'h040, 32'h9999_9999, 4'hF, rd, rv, rp);
      chk("R8 gap wr rsp", 32'(rv), 32'd1);
      acc(1'b0, 12'h1FC, 32'h0, 4'hF, rd, rv, rp);
      chk("R8 gap rd zero", rd, 32'h0);
      chk("R8 gap rd valid", 32'(rv), 32'd1);
      acc(1'b0, 12'h200, 32'h0, 4'h7, rd, rv, rp);
      chk("R8 partial slot rd zero", rd, 32'h0);
      chk("R8 nothing forwarded", 32'(seen_cnt - c0), 32'd0);
      rd_chk("R8 gap no alias word0", 12'h000, 32'h0001_0000);
   endtask

   task automatic t_irq;
      @(negedge clk); slot_irq = 1'b1; #1;
      chk("R9 irq high", 32'(irq), 32'd1);
      @(negedge clk); slot_irq = 1'b0; #1;
      chk("R9 irq low", 32'(irq), 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R4 slot_rst idle after reset", 32'(slot_rst), 32'd0);
      t_reset_values();
      t_plain_rw();
      t_phy();
      t_emmc();
      t_softreset(1'b1);
      t_softreset(1'b0);
      t_slot();
      t_refused();
      t_irq();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule